// File: doc/BRIEF.md
# Process-Tagged Set-Associative Translation Buffer

This block caches virtual-to-physical page translations for a processor core. Each entry records a virtual page number, the identifier of the owning process, a physical frame number and a small permission field. A lookup presents a page number together with the identifier of the running process. One cycle later the block reports hit or miss, and on a hit it also reports the frame and the permissions. An entry counts as a hit only when its owner matches the caller, so entries from several processes can stay resident together and a context switch needs no flush.

The low bits of the page number pick the set directly, and a translation may sit in any way of that set. When a lookup misses, an outside agent (a hardware walker or trap software) finds the translation and writes it in through the fill port. Two purge commands keep the buffer consistent after the translation tables change. One removes a single translation, named by page number and owner. The other removes every translation belonging to one owner, across all sets, in a single cycle.

Top module: `ptag_tlb`

## Requirements
- R1: A lookup presented in cycle N gives `res_valid`=1 with its result in cycle N+1, and `res_valid`=0 after any cycle without a lookup. The result reflects the state before any fill in cycle N, so a fill in the same cycle as a lookup is not seen by that lookup.
- R2: The set index is `vpn[3:0]` (16 sets). Four translations with different upper page bits that share one set can all be resident and hit at the same time.
- R3: A hit requires an equal page number and an equal process identifier. A hit returns the stored frame and permissions. A miss returns `res_hit`=0 with frame and permissions at zero.
- R4: Lookups under a different process identifier do not disturb resident entries. Each owner keeps hitting on its own translation of the same page.
- R5: A single purge removes the entry whose page number and owner both match. A single purge whose owner does not match has no effect.
- R6: A purge by owner clears, in one cycle, every entry with that owner in every set. Entries of other owners are kept.
- R7: A fill for a translation that is not yet present goes to the lowest-numbered invalid way of its set.
- R8: When the set is full, a fill replaces the way named by that set's replacement pointer. The pointer is 0 after reset and advances by one, modulo 4, after each such replacement only.
- R9: A purge issued in the same cycle as a lookup acts first, so that lookup already misses on the purged entry.
- R10: A fill whose page number and owner match a resident entry overwrites that entry in place. No duplicate is created and the replacement pointer does not move.
- R11: A purge and a fill in the same cycle apply in that order, so the filled translation is resident afterwards.
- R12: Reset invalidates every entry and drives `res_valid` and `res_hit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Current process identifier |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup hit |
| res_pfn | output | 20 | Frame number on a hit, else zero |
| res_perm | output | 3 | Permissions on a hit, else zero |
| fill_valid | input | 1 | Insert a translation |
| fill_vpn | input | 20 | Page number to insert |
| fill_pid | input | 8 | Owner of the inserted translation |
| fill_pfn | input | 20 | Frame number to insert |
| fill_perm | input | 3 | Permissions to insert |
| inv_valid | input | 1 | Single-entry purge |
| inv_vpn | input | 20 | Page number to purge |
| inv_pid | input | 8 | Owner of the entry to purge |
| pflush_valid | input | 1 | Purge all entries of one owner |
| pflush_pid | input | 8 | Owner whose entries are purged |

## Verification
The hardest state to reach from the ports is a full set whose replacement pointer has already moved. The same goes for cycles where purge, fill and lookup collide on one entry. The stimulus reaches the first by filling five and then six distinct tags into one set. It reaches the second with directed cycles that drive a lookup or a fill together with a purge. A random phase then uses a small pool of page numbers and owners, so that sets overflow and purges hit live entries often. A behavioural model follows every cycle of this traffic.

// File: rtl/ptag_tlb.sv
module ptag_tlb #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int VPN_W  = 20,
  parameter int PID_W  = 8,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PFN_W-1:0]  res_pfn,
  output logic [PERM_W-1:0] res_perm,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [PID_W-1:0]  inv_pid,
  input  logic              pflush_valid,
  input  logic [PID_W-1:0]  pflush_pid
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0] vld, kill, vld_eff;
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [PID_W-1:0]  pid_q  [SETS][WAYS];
  logic [PFN_W-1:0]  pfn_q  [SETS][WAYS];
  logic [PERM_W-1:0] perm_q [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q   [SETS];

  wire [IDX_W-1:0] lk_idx = lk_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] lk_tag = lk_vpn[VPN_W-1:IDX_W];
  wire [IDX_W-1:0] inv_idx = inv_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] inv_tag = inv_vpn[VPN_W-1:IDX_W];
  wire [IDX_W-1:0] f_idx = fill_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] f_tag = fill_vpn[VPN_W-1:IDX_W];

  always_comb begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        kill[s][w] = vld[s][w] &&
          ((inv_valid && IDX_W'(s) == inv_idx && tag_q[s][w] == inv_tag && pid_q[s][w] == inv_pid) ||
           (pflush_valid && pid_q[s][w] == pflush_pid));
  end
  assign vld_eff = vld & ~kill;

  logic [WAYS-1:0]   hit_vec, fmatch;
  logic [PFN_W-1:0]  hit_pfn;
  logic [PERM_W-1:0] hit_perm;
  logic [WAY_W-1:0]  f_way;
  logic              evict;

  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_eff[lk_idx][w] && tag_q[lk_idx][w] == lk_tag && pid_q[lk_idx][w] == lk_pid;
      fmatch[w]  = vld_eff[f_idx][w] && tag_q[f_idx][w] == f_tag && pid_q[f_idx][w] == fill_pid;
      if (hit_vec[w]) begin
        hit_pfn  = hit_pfn | pfn_q[lk_idx][w];
        hit_perm = hit_perm | perm_q[lk_idx][w];
      end
    end
  end

  always_comb begin
    f_way = rr_q[f_idx];
    evict = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_eff[f_idx][w]) begin
        f_way = WAY_W'(w);
        evict = 1'b0;
      end
    for (int w = 0; w < WAYS; w++)
      if (fmatch[w]) begin
        f_way = WAY_W'(w);
        evict = 1'b0;
      end
  end

  wire hit_any = lk_valid && |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pfn   <= '0;
      res_perm  <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      vld       <= vld_eff;
      res_valid <= lk_valid;
      res_hit   <= hit_any;
      res_pfn   <= hit_any ? hit_pfn : '0;
      res_perm  <= hit_any ? hit_perm : '0;
      if (fill_valid) begin
        vld[f_idx][f_way]    <= 1'b1;
        tag_q[f_idx][f_way]  <= f_tag;
        pid_q[f_idx][f_way]  <= fill_pid;
        pfn_q[f_idx][f_way]  <= fill_pfn;
        perm_q[f_idx][f_way] <= fill_perm;
        if (evict) rr_q[f_idx] <= rr_q[f_idx] + 1'b1;
      end
    end
  end

  p_res_valid_r1: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> res_valid);
  p_res_idle_r1:  assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !res_valid);
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n) !res_hit |-> (res_pfn == '0 && res_perm == '0));
  p_hit_unique_r10: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |-> $onehot0(hit_vec));
  p_victim_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !(|fmatch) && !(&vld_eff[f_idx])) |-> !vld_eff[f_idx][f_way]);

  for (genvar s = 0; s < SETS; s++) begin : g_chk_set
    p_rr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && evict && f_idx == IDX_W'(s)) |=> rr_q[s] == WAY_W'($past(rr_q[s]) + 1'b1));
    p_rr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && evict && f_idx == IDX_W'(s)) |=> $stable(rr_q[s]));
    for (genvar w = 0; w < WAYS; w++) begin : g_chk_way
      p_fill_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && f_idx == IDX_W'(s) && f_way == WAY_W'(w)) |=> (vld[s][w] && pid_q[s][w] == $past(fill_pid)));
      p_owner_purge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pflush_valid && !(fill_valid && f_idx == IDX_W'(s) && f_way == WAY_W'(w)))
        |=> !(vld[s][w] && pid_q[s][w] == $past(pflush_pid)));
    end
  end
endmodule

// File: tb/tb_ptag_tlb.sv
module tb_ptag_tlb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_valid = 0, inv_valid = 0, pflush_valid = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, inv_vpn = 0, fill_pfn = 0;
  logic [7:0]  lk_pid = 0, fill_pid = 0, inv_pid = 0, pflush_pid = 0;
  logic [2:0]  fill_perm = 0;
  logic res_valid, res_hit;
  logic [19:0] res_pfn;
  logic [2:0]  res_perm;

  ptag_tlb dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R12";

  bit mv [16][4];
  int mvpn [16][4], mpid [16][4], mpfn [16][4], mperm [16][4];
  int mrr [16];
  bit e_valid, e_hit;
  int e_pfn, e_perm;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mv[s, w]) mv[s][w] = 0;
      foreach (mrr[s]) mrr[s] = 0;
      e_valid = 0; e_hit = 0; e_pfn = 0; e_perm = 0;
    end else begin
      foreach (mv[s, w])
        if (mv[s][w] && ((inv_valid && mvpn[s][w] == int'(inv_vpn) && mpid[s][w] == int'(inv_pid)) ||
                         (pflush_valid && mpid[s][w] == int'(pflush_pid))))
          mv[s][w] = 0;
      e_valid = lk_valid; e_hit = 0; e_pfn = 0; e_perm = 0;
      if (lk_valid) begin
        int s;
        s = int'(lk_vpn) % 16;
        for (int w = 0; w < 4; w++)
          if (mv[s][w] && mvpn[s][w] == int'(lk_vpn) && mpid[s][w] == int'(lk_pid)) begin
            e_hit = 1; e_pfn = mpfn[s][w]; e_perm = mperm[s][w];
          end
      end
      if (fill_valid) begin
        int s, way;
        s = int'(fill_vpn) % 16;
        way = -1;
        for (int w = 0; w < 4; w++)
          if (way < 0 && mv[s][w] && mvpn[s][w] == int'(fill_vpn) && mpid[s][w] == int'(fill_pid)) way = w;
        for (int w = 0; w < 4; w++)
          if (way < 0 && !mv[s][w]) way = w;
        if (way < 0) begin way = mrr[s]; mrr[s] = (mrr[s] + 1) % 4; end
        mv[s][way] = 1; mvpn[s][way] = int'(fill_vpn); mpid[s][way] = int'(fill_pid);
        mpfn[s][way] = int'(fill_pfn); mperm[s][way] = int'(fill_perm);
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (res_valid !== e_valid || res_hit !== e_hit || int'(res_pfn) !== e_pfn || int'(res_perm) !== e_perm) begin
      fails++;
      $display("FAIL %s: got valid=%0d hit=%0d pfn=%h perm=%0d, expected valid=%0d hit=%0d pfn=%h perm=%0d",
               cur_req, res_valid, res_hit, res_pfn, res_perm, e_valid, e_hit, e_pfn, e_perm);
    end
  end

  task automatic clr();
    lk_valid = 0; fill_valid = 0; inv_valid = 0; pflush_valid = 0;
  endtask
  task automatic look(input int v, input int p);
    lk_valid = 1; lk_vpn = 20'(v); lk_pid = 8'(p);
    @(negedge clk); clr();
  endtask
  task automatic put(input int v, input int p, input int f, input int pm);
    fill_valid = 1; fill_vpn = 20'(v); fill_pid = 8'(p); fill_pfn = 20'(f); fill_perm = 3'(pm);
    @(negedge clk); clr();
  endtask
  task automatic purge(input int v, input int p);
    inv_valid = 1; inv_vpn = 20'(v); inv_pid = 8'(p);
    @(negedge clk); clr();
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R12";
    look(20'h00003, 1); look(20'h12345, 0); @(negedge clk);
    cur_req = "R7";
    for (int t = 1; t <= 4; t++) put((t << 4) | 3, 1, 16'h100 + t, t);
    cur_req = "R2";
    for (int t = 1; t <= 4; t++) look((t << 4) | 3, 1);
    cur_req = "R8";
    put((5 << 4) | 3, 1, 20'h155, 5); look(8'h13, 1); look(8'h53, 1); look(8'h23, 1);
    put((6 << 4) | 3, 1, 20'h166, 6); look(8'h23, 1); look(8'h63, 1); look(8'h33, 1);
    cur_req = "R4";
    put(20'hABC07, 2, 20'h2222, 1); put(20'hABC07, 5, 20'h5555, 2);
    look(20'hABC07, 2); look(20'hABC07, 5); look(20'hABC07, 9); look(20'hABC07, 2);
    cur_req = "R1";
    lk_valid = 1; lk_vpn = 20'h0F00A; lk_pid = 3;
    fill_valid = 1; fill_vpn = 20'h0F00A; fill_pid = 3; fill_pfn = 20'h0AAAA; fill_perm = 7;
    @(negedge clk); clr();
    @(negedge clk); look(20'h0F00A, 3);
    cur_req = "R5";
    purge(20'hABC07, 9); look(20'hABC07, 2);
    purge(20'hABC07, 2); look(20'hABC07, 2); look(20'hABC07, 5);
    cur_req = "R9";
    lk_valid = 1; lk_vpn = 20'hABC07; lk_pid = 5; inv_valid = 1; inv_vpn = 20'hABC07; inv_pid = 5;
    @(negedge clk); clr(); look(20'hABC07, 5);
    cur_req = "R6";
    for (int t = 0; t < 6; t++) put(20'h70000 + t * 17, 4, 20'h400 + t, 3);
    put(20'h70000, 6, 20'h600, 1);
    pflush_valid = 1; pflush_pid = 4; @(negedge clk); clr();
    for (int t = 0; t < 6; t++) look(20'h70000 + t * 17, 4);
    look(20'h70000, 6); look(8'h63, 1);
    cur_req = "R10";
    put(8'h63, 1, 20'h9999, 4); look(8'h63, 1);
    put(8'h73, 1, 20'h177, 7); look(8'h33, 1); look(8'h63, 1); look(8'h73, 1);
    cur_req = "R11";
    inv_valid = 1; inv_vpn = 20'h0F00A; inv_pid = 3;
    fill_valid = 1; fill_vpn = 20'h0F00A; fill_pid = 3; fill_pfn = 20'h0BBBB; fill_perm = 2;
    @(negedge clk); clr(); look(20'h0F00A, 3);
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      lk_valid = ($urandom % 2) == 1; lk_vpn = 20'({$urandom % 4, 4'($urandom % 3)}); lk_pid = 8'($urandom % 3);
      fill_valid = ($urandom % 3) == 0; fill_vpn = 20'({$urandom % 8, 4'($urandom % 3)});
      fill_pid = 8'($urandom % 3); fill_pfn = 20'($urandom); fill_perm = 3'($urandom);
      inv_valid = ($urandom % 6) == 0; inv_vpn = 20'({$urandom % 4, 4'($urandom % 3)}); inv_pid = 8'($urandom % 3);
      pflush_valid = ($urandom % 40) == 0; pflush_pid = 8'($urandom % 3);
      @(negedge clk);
    end
    clr();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule